// File: doc/BRIEF.md
# Maskable External Status Interrupt Latch

The block watches six condition inputs: carrier detect, sync/hunt, clear-to-send, transmit underrun or end-of-message, zero count and break/abort. When a condition changes on a source whose enable bit is set, and the group enable is also high, the block raises a pending interrupt. At that edge it captures a copy of all six inputs. The pending flag and the copy then hold until the host issues a reset-interrupt command.

The host writes an eight-bit configuration word and can read it back. The low six bits enable the sources one by one. The top two bits are unrelated control flags that are only stored. A source takes part only once its enable is already in the register, so a transition that happened before the enable, or in the cycle the enable is written, never produces an interrupt.

Top module: `ext_stat_irq_latch`

## Requirements
- R1: While rst_ni is low and after it is released, pending_o, irq_o, snap_o and cfg_rdata_o are all zero.
- R2: When cfg_we_i is high at a clock edge, all eight bits of cfg_wdata_i appear on cfg_rdata_o from the following cycle and hold until the next write.
- R3: Source bits 0 (carrier detect), 1 (sync/hunt) and 2 (clear-to-send) of cond_i produce an event on any level change. Source bits 3 (underrun/end-of-message), 4 (zero count) and 5 (break/abort) produce an event only on a 0-to-1 change. A falling edge on bits 3 to 5 has no effect.
- R4: An event on source bit i can set pending only if cfg bit i was already stored before the clock edge at which the event is sampled. Events on sources that are not enabled are ignored.
- R5: A condition that changed before its enable was stored, or in the same edge as the enable write, does not set pending. A later transition on that source does set it.
- R6: While grp_en_i is low, no event sets pending.
- R7: When an accepted event is sampled at an edge, pending_o is high from the next cycle, and snap_o equals the value of cond_i at that edge.
- R8: While pending_o is high, further events change neither pending_o nor snap_o.
- R9: rst_irq_i high at an edge clears pending_o from the next cycle. It takes priority over an event sampled at the same edge, and that event is discarded.
- R10: irq_o equals pending_o AND grp_en_i, in the same cycle.
- R11: cfg bits 6 (status FIFO enable) and 7 (protocol enhancement enable) are stored and read back, but have no effect on pending_o or irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low hardware reset |
| cond_i | input | 6 | Condition inputs, bit order as in R3 |
| grp_en_i | input | 1 | Group enable for all external/status interrupts |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 8 | Configuration write data: [5:0] source enables, [6] status FIFO enable, [7] protocol enhancement enable |
| cfg_rdata_o | output | 8 | Stored configuration word |
| rst_irq_i | input | 1 | Host reset-interrupt command |
| pending_o | output | 1 | Latched pending flag |
| irq_o | output | 1 | Interrupt request |
| snap_o | output | 6 | Condition inputs captured when pending set |

## Verification
The assertions check the following on every cycle:
- the write-to-readback timing of the configuration word;
- the output gating by the group enable;
- the hold of pending_o and snap_o while pending is set;
- the priority of the clear command;
- that pending never sets with the group enable low or with all enables clear;
- that a rising pending flag matches the previous cycle's inputs.

Which transitions count as events depends on the edge type of each source and on the order between the enable write and the transition. These properties, including the rule that an already-present condition is ignored, need the directed sequences in the bench. The bench covers them with a reference model compared on every clock, and follows with a random phase.

// File: rtl/ext_stat_pkg.sv
package ext_stat_pkg;
  localparam int unsigned ESI_NUM_SRC = 6;
  localparam int unsigned ESI_CFG_W   = 8;
  // sources that fire on any change; others fire on rising edge only
  localparam logic [ESI_NUM_SRC-1:0] ESI_LEVEL_MASK = 6'b000111;

  typedef enum int unsigned {
    SRC_CARRIER = 0,
    SRC_SYNC    = 1,
    SRC_CTS     = 2,
    SRC_UNDERRUN = 3,
    SRC_ZCOUNT  = 4,
    SRC_BREAK   = 5
  } esi_src_e;

  localparam int unsigned CFG_FIFO_BIT = 6;
  localparam int unsigned CFG_ENH_BIT  = 7;
endpackage

// File: rtl/esi_evt_det.sv
module esi_evt_det #(
  parameter int unsigned NUM_SRC = 6,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] cond_i,
  output logic [NUM_SRC-1:0] evt_o
);
  logic [NUM_SRC-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= cond_i;
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    if (LEVEL_MASK[g]) begin : g_lvl
      assign evt_o[g] = cond_i[g] ^ prev_q[g];
    end else begin : g_rise
      assign evt_o[g] = cond_i[g] & ~prev_q[g];
    end
  end
endmodule

// File: rtl/esi_cfg_reg.sv
module esi_cfg_reg #(
  parameter int unsigned CFG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output logic [CFG_W-1:0] cfg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_o <= '0;
    else if (we_i) cfg_o <= wdata_i;
  end
endmodule

// File: rtl/esi_pending.sv
module esi_pending #(
  parameter int unsigned NUM_SRC = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hit_i,
  input  logic               grp_en_i,
  input  logic               clr_i,
  input  logic [NUM_SRC-1:0] cond_i,
  output logic               pend_o,
  output logic [NUM_SRC-1:0] snap_o
);
  logic set_w;
  assign set_w = hit_i & grp_en_i & ~pend_o & ~clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o <= 1'b0;
      snap_o <= '0;
    end else if (clr_i) begin
      pend_o <= 1'b0;
    end else if (set_w) begin
      pend_o <= 1'b1;
      snap_o <= cond_i;
    end
  end
endmodule

// File: rtl/ext_stat_irq_latch.sv
module ext_stat_irq_latch
  import ext_stat_pkg::*;
#(
  parameter int unsigned NUM_SRC = ESI_NUM_SRC,
  parameter int unsigned CFG_W   = ESI_CFG_W,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = ESI_LEVEL_MASK
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] cond_i,
  input  logic               grp_en_i,
  input  logic               cfg_we_i,
  input  logic [CFG_W-1:0]   cfg_wdata_i,
  output logic [CFG_W-1:0]   cfg_rdata_o,
  input  logic               rst_irq_i,
  output logic               pending_o,
  output logic               irq_o,
  output logic [NUM_SRC-1:0] snap_o
);
  logic [NUM_SRC-1:0] evt_w;
  logic [CFG_W-1:0]   cfg_q;
  logic               hit_w;

  esi_evt_det #(.NUM_SRC(NUM_SRC), .LEVEL_MASK(LEVEL_MASK)) u_evt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cond_i(cond_i),
    .evt_o (evt_w)
  );

  esi_cfg_reg #(.CFG_W(CFG_W)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .wdata_i(cfg_wdata_i),
    .cfg_o  (cfg_q)
  );

  // stored enable (pre-edge value) gates events: same-edge writes never fire
  assign hit_w = |(evt_w & cfg_q[NUM_SRC-1:0]);

  esi_pending #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hit_i   (hit_w),
    .grp_en_i(grp_en_i),
    .clr_i   (rst_irq_i),
    .cond_i  (cond_i),
    .pend_o  (pending_o),
    .snap_o  (snap_o)
  );

  assign cfg_rdata_o = cfg_q;
  assign irq_o       = pending_o & grp_en_i;
endmodule

// File: rtl/esi_chk.sv
module esi_chk #(
  parameter int unsigned NUM_SRC = 6,
  parameter int unsigned CFG_W   = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] cond_i,
  input logic               grp_en_i,
  input logic               cfg_we_i,
  input logic [CFG_W-1:0]   cfg_wdata_i,
  input logic [CFG_W-1:0]   cfg_rdata_o,
  input logic               rst_irq_i,
  input logic               pending_o,
  input logic               irq_o,
  input logic [NUM_SRC-1:0] snap_o
);
  always_comb begin
    if (!rst_ni) begin
      AST_RESET_IDLE: assert (!pending_o && !irq_o && snap_o == '0 && cfg_rdata_o == '0); // R1
    end
  end

  AST_CFG_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> cfg_rdata_o == $past(cfg_wdata_i)); // R2

  AST_NO_SET_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pending_o && cfg_rdata_o[NUM_SRC-1:0] == '0) |=> !pending_o); // R4

  AST_NO_SET_GRP_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pending_o && !grp_en_i) |=> !pending_o); // R6

  AST_SNAP_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pending_o) |-> (snap_o == $past(cond_i) && $past(grp_en_i) && !$past(rst_irq_i))); // R7

  AST_PEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_o && !rst_irq_i) |=> (pending_o && $stable(snap_o))); // R8

  AST_CLR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_irq_i |=> !pending_o); // R9

  AST_IRQ_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (pending_o && grp_en_i)); // R10
endmodule

bind ext_stat_irq_latch esi_chk #(.NUM_SRC(NUM_SRC), .CFG_W(CFG_W)) u_esi_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cond_i     (cond_i),
  .grp_en_i   (grp_en_i),
  .cfg_we_i   (cfg_we_i),
  .cfg_wdata_i(cfg_wdata_i),
  .cfg_rdata_o(cfg_rdata_o),
  .rst_irq_i  (rst_irq_i),
  .pending_o  (pending_o),
  .irq_o      (irq_o),
  .snap_o     (snap_o)
);

// File: tb/ext_stat_irq_latch_tb_top.sv
module ext_stat_irq_latch_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] cond = '0;
  logic       grp_en = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       rst_irq = 1'b0;
  logic       pending, irq;
  logic [5:0] snap;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string cur_req = "R1";

  // reference model state
  bit       m_pend;
  bit [5:0] m_snap, m_prev;
  bit [7:0] m_cfg;

  always #2 clk = ~clk; // 250 MHz

  ext_stat_irq_latch dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cond_i(cond), .grp_en_i(grp_en),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .rst_irq_i(rst_irq), .pending_o(pending), .irq_o(irq), .snap_o(snap)
  );

  task automatic check(string req, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    check(cur_req, pending, m_pend, "pending");
    check(cur_req, irq, m_pend & grp_en, "irq");
    check(cur_req, snap, m_snap, "snap");
    check(cur_req, cfg_rdata, m_cfg, "cfg");
  endtask

  // advance one clock: model next state from pre-edge inputs, then compare
  task automatic tick();
    bit       n_pend;
    bit [5:0] n_snap;
    bit [7:0] n_cfg;
    bit       hit;
    n_pend = m_pend; n_snap = m_snap; n_cfg = m_cfg;
    hit = 0;
    for (int i = 0; i < 6; i++) begin
      bit ev;
      if (i < 3) ev = cond[i] != m_prev[i];
      else       ev = cond[i] && !m_prev[i];
      if (ev && m_cfg[i]) hit = 1;
    end
    if (rst_irq) n_pend = 0;
    else if (!m_pend && hit && grp_en) begin
      n_pend = 1; n_snap = cond;
    end
    if (cfg_we) n_cfg = cfg_wdata;
    @(posedge clk);
    #1;
    m_pend = n_pend; m_snap = n_snap; m_cfg = n_cfg; m_prev = cond;
    compare_all();
  endtask

  task automatic wr_cfg(bit [7:0] v);
    cfg_we = 1; cfg_wdata = v; tick(); cfg_we = 0;
  endtask

  task automatic clr_irq();
    rst_irq = 1; tick(); rst_irq = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    m_pend = 0; m_snap = '0; m_prev = '0; m_cfg = '0;
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    cur_req = "R1"; compare_all();
    rst_n = 1;
    tick(); tick();

    // R11 + R2: only non-interrupt bits set, every source toggles
    cur_req = "R11"; grp_en = 1;
    wr_cfg(8'hC0);
    check("R2", cfg_rdata, 8'hC0, "cfg readback");
    cond = 6'h3F; tick(); cond = 6'h00; tick(); tick();
    check("R11", pending, 0, "pending with bits 6/7 only");

    // R5: underrun already high in the enable-write edge
    cur_req = "R5";
    cond = 6'b001000; wr_cfg(8'h3F); tick(); tick();
    check("R5", pending, 0, "pre-existing condition");
    // R3: falling edge on rise-only source ignored
    cur_req = "R3";
    cond = 6'b000000; tick(); tick();
    check("R3", pending, 0, "falling edge on bit 3");
    // R7: later rising edge fires
    cur_req = "R7";
    cond = 6'b001000; tick();
    check("R7", pending, 1, "rising edge bit 3");
    check("R7", snap, 6'b001000, "snapshot");

    // R8: further events ignored
    cur_req = "R8";
    cond = 6'b001011; tick(); cond = 6'b000001; tick();
    check("R8", snap, 6'b001000, "snapshot hold");
    check("R8", pending, 1, "pending hold");

    // R10: group enable drop masks irq but keeps pending
    cur_req = "R10";
    grp_en = 0; tick();
    check("R10", irq, 0, "irq masked");
    check("R10", pending, 1, "pending kept");
    grp_en = 1; tick();
    check("R10", irq, 1, "irq back");

    // R9: clear beats a simultaneous event
    cur_req = "R9";
    rst_irq = 1; cond = 6'b000011; tick(); rst_irq = 0;
    check("R9", pending, 0, "clear priority");
    tick();
    check("R9", pending, 0, "discarded event");

    // R6: group off blocks setting
    cur_req = "R6";
    grp_en = 0; cond = 6'b000000; tick(); cond = 6'b010000; tick();
    check("R6", pending, 0, "group off");
    grp_en = 1; tick();
    check("R6", pending, 0, "no late set");

    // R3: falling level change on clear-to-send fires
    cur_req = "R3";
    cond = 6'b010100; tick(); clr_irq(); tick();
    check("R3", pending, 0, "cleared");
    cond = 6'b010000; tick();
    check("R3", pending, 1, "cts falling fires");
    check("R3", snap, 6'b010000, "snapshot cts fall");
    clr_irq();

    // R4: only sync enabled, other sources ignored
    cur_req = "R4";
    wr_cfg(8'h02);
    cond = 6'b111101; tick(); cond = 6'b000000; tick();
    check("R4", pending, 0, "disabled sources");
    cond = 6'b000010; tick();
    check("R4", pending, 1, "enabled sync fires");
    clr_irq();

    // random phase against model
    cur_req = "R4";
    for (int k = 0; k < 400; k++) begin
      cond = 6'($urandom);
      grp_en = ($urandom % 4) != 0;
      rst_irq = ($urandom % 8) == 0;
      cfg_we = ($urandom % 10) == 0;
      cfg_wdata = 8'($urandom);
      tick();
    end
    rst_irq = 0; cfg_we = 0;

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule